// File: doc/BRIEF.md
# Channel-Status Bit Access Port

This block keeps the 32 transmit channel-status bits of a digital audio interface and gives a host narrow, one-bit-at-a-time access to them. It also offers a receiver status byte. The host bus has two byte-wide registers, picked by a one-bit address. The control/status register (address 0) sets the access mode when written. When read, it returns the receiver's clock and data presence, an encoded sample rate, and the received format bit. The bit-access register (address 1) carries a 5-bit bit index in its low bits and a bit value in bit 7.

In write mode, writing the bit-access register stores bit 7 into the addressed transmit channel-status bit. In read mode, the same write only selects an index. A following read of the register then returns the addressed received channel-status bit in bit 7. Serial framing of the audio stream happens elsewhere. The received channel-status word, the lock flags and a one-hot rate indication come in as plain inputs. The stored transmit word goes out as a plain output.

Top module: `cs_bit_port`

## Requirements
- R1: After a synchronous active-low reset, the mode is write mode, the selected index is 0 and all 32 bits of `tx_cs_bits` are 0.
- R2: A host write to address 0 selects read mode if `host_wdata[0]` is 1 and write mode if it is 0; other data bits have no effect. The mode does not change on any write to address 1.
- R3: In write mode, a host write to address 1 sets `tx_cs_bits[host_wdata[4:0]]` to `host_wdata[7]` at the next clock edge and leaves every other transmit bit unchanged.
- R4: Only `host_wdata[4:0]` forms the index; `host_wdata[6:5]` are ignored. Reads of address 1 return 0 in bits 6:5 and the selected index in bits 4:0.
- R5: In read mode, a host write to address 1 selects the index and leaves `tx_cs_bits` unchanged. A read of address 1 then returns `rx_cs_bits[index]` in bit 7.
- R6: In write mode, a read of address 1 returns `tx_cs_bits[index]` in bit 7.
- R7: A read of address 0 returns `rx_clk_present` in bit 0, `rx_data_present` in bit 1, the current mode in bit 7 (1 = read mode), and 0 in bits 6:5.
- R8: Status bits 3:2 give the rate code: 00 when `rx_rate_hot` is 3'b001 (32 kHz), 01 for 3'b010 (44.1 kHz), 10 for 3'b100 (48 kHz), and 11 for any other pattern. The field reads 00 whenever `rx_clk_present` is 0.
- R9: Status bit 4 reports the received format bit `rx_cs_bits[0]` (1 = professional, 0 = consumer) while `rx_data_present` is 1, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 1 | Register select: 0 control/status, 1 bit access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the register picked by `host_addr` |
| rx_cs_bits | input | 32 | Received channel-status word |
| rx_clk_present | input | 1 | Receiver clock present |
| rx_data_present | input | 1 | Receiver data present |
| rx_rate_hot | input | 3 | One-hot detected rate: bit0 32 kHz, bit1 44.1 kHz, bit2 48 kHz |
| tx_cs_bits | output | 32 | Stored transmit channel-status word |

## Verification
The case that is hardest to reach from the ports is a bit-access write made in read mode. It must move the index but leave all 32 stored transmit bits alone, even when its bit 7 differs from the stored bit. The bench first fills the transmit word with a known pattern in write mode. It then switches to read mode and writes every index with the inverted value and with bits 6:5 set, comparing the whole transmit word and the read-back byte after each write. The status byte is swept over every combination of clock presence, data presence, one-hot rate pattern and received format bit.

// File: rtl/cs_port_pkg.sv
// Package cs_port_pkg
// Shared mode type and status byte bit positions for the channel-status
// bit access port. Assumes an 8-bit host data path.
package cs_port_pkg;

    typedef enum logic {
        MODE_WRITE = 1'b0,
        MODE_READ  = 1'b1
    } cs_mode_e;

    localparam int HOST_DW      = 8;
    localparam int VAL_BIT      = 7;
    localparam int ST_CLK_BIT   = 0;
    localparam int ST_DATA_BIT  = 1;
    localparam int ST_RATE_LO   = 2;
    localparam int ST_PRO_BIT   = 4;
    localparam int ST_MODE_BIT  = 7;

    localparam logic [1:0] RATE_32K     = 2'b00;
    localparam logic [1:0] RATE_44K1    = 2'b01;
    localparam logic [1:0] RATE_48K     = 2'b10;
    localparam logic [1:0] RATE_UNKNOWN = 2'b11;

endpackage

// File: rtl/cs_mode_index_reg.sv
// Module cs_mode_index_reg
// Holds the access mode and the selected bit index. The mode changes only on
// control-register writes. The index is taken from the low IDX_W bits of
// every bit-access write, whatever the mode. Assumes IDX_W < HOST_DW - 1.
module cs_mode_index_reg
    import cs_port_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic               data_wr,
    input  logic [HOST_DW-1:0] wdata,
    output cs_mode_e           mode,
    output logic [IDX_W-1:0]   idx
);

    // Mode register: bit 0 of a control write picks read or write mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_WRITE;
        end else if (ctrl_wr) begin
            mode <= wdata[0] ? MODE_READ : MODE_WRITE;
        end
    end

    // Index register: the masked low field of each bit-access write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (data_wr) begin
            idx <= wdata[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/cs_bit_store.sv
// Module cs_bit_store
// Storage for the transmit channel-status word, one flop per bit, each with
// its own enable from the index decode. Assumes set_en is a single-cycle
// strobe that is only raised in write mode.
module cs_bit_store #(
    parameter int CS_BITS = 32,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               set_val,
    output logic [CS_BITS-1:0] bits
);

    genvar g;
    generate
        for (g = 0; g < CS_BITS; g++) begin : g_bit
            logic hit;
            // Decode: this bit is the target of the current store.
            always_comb hit = set_en && (set_idx == IDX_W'(g));

            // Bit flop: load the new value on a hit, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bits[g] <= 1'b0;
                end else if (hit) begin
                    bits[g] <= set_val;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cs_rate_encode.sv
// Module cs_rate_encode
// Turns the receiver's one-hot rate indication into a 2-bit code. Zero or
// several hot bits give the unknown code. With no clock present the field
// is forced to zero.
module cs_rate_encode
    import cs_port_pkg::*;
(
    input  logic       clk_present,
    input  logic [2:0] rate_hot,
    output logic [1:0] rate_code
);

    logic [1:0] raw_code;

    // Encoder: map exactly-one-hot patterns, everything else is unknown.
    always_comb begin
        case (rate_hot)
            3'b001:  raw_code = RATE_32K;
            3'b010:  raw_code = RATE_44K1;
            3'b100:  raw_code = RATE_48K;
            default: raw_code = RATE_UNKNOWN;
        endcase
    end

    // Gate: no clock means no meaningful rate.
    always_comb rate_code = clk_present ? raw_code : 2'b00;

endmodule

// File: rtl/cs_bit_port.sv
// Module cs_bit_port
// Host access port for the channel-status bits. Address 0 is the
// control/status register and address 1 is the bit-access register. Reads
// are combinational from host_addr. Assumes the host holds host_wr for
// exactly one cycle per write.
module cs_bit_port
    import cs_port_pkg::*;
#(
    parameter int CS_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_addr,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic [CS_BITS-1:0] rx_cs_bits,
    input  logic               rx_clk_present,
    input  logic               rx_data_present,
    input  logic [2:0]         rx_rate_hot,
    output logic [CS_BITS-1:0] tx_cs_bits
);

    localparam int IDX_W = $clog2(CS_BITS);
    localparam int PAD_W = HOST_DW - 1 - IDX_W;

    logic             ctrl_wr;
    logic             data_wr;
    cs_mode_e         mode;
    logic [IDX_W-1:0] idx;
    logic [1:0]       rate_code;
    logic             sel_bit;
    logic [7:0]       status_byte;
    logic [7:0]       access_byte;

    // Write decode: split the host strobe by register address.
    always_comb begin
        ctrl_wr = host_wr && !host_addr;
        data_wr = host_wr && host_addr;
    end

    cs_mode_index_reg #(.IDX_W(IDX_W)) u_mode_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .data_wr (data_wr),
        .wdata   (host_wdata),
        .mode    (mode),
        .idx     (idx)
    );

    cs_bit_store #(.CS_BITS(CS_BITS), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (data_wr && (mode == MODE_WRITE)),
        .set_idx (host_wdata[IDX_W-1:0]),
        .set_val (host_wdata[VAL_BIT]),
        .bits    (tx_cs_bits)
    );

    cs_rate_encode u_rate (
        .clk_present (rx_clk_present),
        .rate_hot    (rx_rate_hot),
        .rate_code   (rate_code)
    );

    // Bit select: received word in read mode, stored word in write mode.
    always_comb sel_bit = (mode == MODE_READ) ? rx_cs_bits[idx] : tx_cs_bits[idx];

    // Status byte assembly from receiver flags, rate code and mode.
    always_comb begin
        status_byte                     = '0;
        status_byte[ST_CLK_BIT]         = rx_clk_present;
        status_byte[ST_DATA_BIT]        = rx_data_present;
        status_byte[ST_RATE_LO +: 2]    = rate_code;
        status_byte[ST_PRO_BIT]         = rx_data_present && rx_cs_bits[0];
        status_byte[ST_MODE_BIT]        = (mode == MODE_READ);
    end

    // Bit-access byte: value on top, zero padding, index at the bottom.
    always_comb access_byte = {sel_bit, {PAD_W{1'b0}}, idx};

    // Read mux by address.
    always_comb host_rdata = host_addr ? access_byte : status_byte;

endmodule

// File: rtl/cs_bit_port_checker.sv
// Module cs_bit_port_checker
// Temporal checks on the channel-status bit access port, bound to every
// instance of cs_bit_port.
module cs_bit_port_checker #(
    parameter int CS_BITS = 32,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               host_addr,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata,
    input logic               rx_clk_present,
    input logic               mode_rd,
    input logic [CS_BITS-1:0] tx_cs_bits
);

    AST_MODE_HOLDS_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr) |=> $stable(mode_rd)); // R2

    AST_MODE_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_addr) |=> (mode_rd == $past(host_wdata[0]))); // R2

    AST_WRITE_STORES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr && !mode_rd) |=>
        (tx_cs_bits[$past(host_wdata[IDX_W-1:0])] == $past(host_wdata[7]))); // R3

    AST_TX_HOLDS_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr && !mode_rd) |=> $stable(tx_cs_bits)); // R5

    AST_ACCESS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr |-> (host_rdata[6:5] == 2'b00)); // R4

    AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !host_addr |-> (host_rdata[6:5] == 2'b00)); // R7

    AST_RATE_ZERO_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_addr && !rx_clk_present) |-> (host_rdata[3:2] == 2'b00)); // R8

endmodule

bind cs_bit_port cs_bit_port_checker #(.CS_BITS(CS_BITS), .IDX_W(IDX_W)) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_wr        (host_wr),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .host_rdata     (host_rdata),
    .rx_clk_present (rx_clk_present),
    .mode_rd        (mode == cs_port_pkg::MODE_READ),
    .tx_cs_bits     (tx_cs_bits)
);

// File: tb/cs_bit_port_tb_top.sv
// Bench for cs_bit_port: sweeps every index in both modes and every status
// input combination, with expected values computed from the requirements.
module cs_bit_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [31:0] rx_cs_bits = '0;
    logic        rx_clk_present = 1'b0;
    logic        rx_data_present = 1'b0;
    logic [2:0]  rx_rate_hot = '0;
    logic [31:0] tx_cs_bits;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] m_tx = '0;
    logic [4:0]  m_idx = '0;
    logic        m_rd = 1'b0;

    always #4 clk = ~clk;

    cs_bit_port dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .host_wr         (host_wr),
        .host_addr       (host_addr),
        .host_wdata      (host_wdata),
        .host_rdata      (host_rdata),
        .rx_cs_bits      (rx_cs_bits),
        .rx_clk_present  (rx_clk_present),
        .rx_data_present (rx_data_present),
        .rx_rate_hot     (rx_rate_hot),
        .tx_cs_bits      (tx_cs_bits)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle host write; returns at the next falling edge with outputs settled.
    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    task automatic read_byte(input logic a, output logic [7:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    function automatic logic [1:0] exp_rate(input logic clkp, input logic [2:0] hot);
        if (!clkp) return 2'b00;
        case (hot)
            3'b001: return 2'b00;
            3'b010: return 2'b01;
            3'b100: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [7:0] rb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 tx word", tx_cs_bits, 32'h0);
        read_byte(1'b1, rb);
        check("R1 index/bit", {24'h0, rb}, 32'h0);
        read_byte(1'b0, rb);
        check("R1 mode", {31'h0, rb[7]}, 32'h0);

        // R3/R6: fill the transmit word in write mode, index by index
        for (int i = 0; i < 32; i++) begin
            logic v;
            v = ((i * 7 + 3) % 5) < 2;
            host_write(1'b1, {v, 2'b00, 5'(i)});
            m_tx[i] = v; m_idx = 5'(i);
            check("R3 tx word after store", tx_cs_bits, m_tx);
            read_byte(1'b1, rb);
            check("R6 write-mode readback", {24'h0, rb}, {24'h0, m_tx[m_idx], 2'b00, m_idx});
        end

        // R4: upper index bits are ignored on a store
        for (int i = 0; i < 32; i++) begin
            logic v;
            v = ~m_tx[i];
            host_write(1'b1, {v, 2'b11, 5'(i)});
            m_tx[i] = v; m_idx = 5'(i);
            check("R4 masked index store", tx_cs_bits, m_tx);
            read_byte(1'b1, rb);
            check("R4 index readback", {24'h0, rb}, {24'h0, m_tx[m_idx], 2'b00, m_idx});
        end

        // R2: other control bits do not pick the mode
        host_write(1'b0, 8'hFE);
        read_byte(1'b0, rb);
        check("R2 write mode via bit0=0", {31'h0, rb[7]}, 32'h0);
        host_write(1'b0, 8'h01);
        m_rd = 1'b1;
        read_byte(1'b0, rb);
        check("R2 read mode via bit0=1", {31'h0, rb[7]}, 32'h1);

        // R5: read mode, writes move index only; R2 mode holds across data writes
        rx_cs_bits = 32'hA5C3_0F96;
        for (int i = 0; i < 32; i++) begin
            host_write(1'b1, {~m_tx[i], 2'b11, 5'(i)});
            m_idx = 5'(i);
            check("R5 tx untouched in read mode", tx_cs_bits, m_tx);
            read_byte(1'b1, rb);
            check("R5 received bit readback", {24'h0, rb}, {24'h0, rx_cs_bits[m_idx], 2'b00, m_idx});
            read_byte(1'b0, rb);
            check("R2 mode held", {31'h0, rb[7]}, 32'h1);
        end
        rx_cs_bits = ~rx_cs_bits;
        read_byte(1'b1, rb);
        check("R5 live received bit", {31'h0, rb[7]}, {31'h0, rx_cs_bits[m_idx]});

        // R7/R8/R9: sweep every status input combination
        for (int c = 0; c < 64; c++) begin
            rx_clk_present  = c[0];
            rx_data_present = c[1];
            rx_rate_hot     = c[4:2];
            rx_cs_bits[0]   = c[5];
            read_byte(1'b0, rb);
            check("R7 status flags", {24'h0, rb[7], rb[6:5], rb[1:0]},
                  {24'h0, m_rd, 2'b00, c[1], c[0]});
            check("R8 rate code", {30'h0, rb[3:2]}, {30'h0, exp_rate(c[0], c[4:2])});
            check("R9 format bit", {31'h0, rb[4]}, {31'h0, c[1] & c[5]});
        end

        // R1: reset again from a non-zero state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 tx cleared", tx_cs_bits, 32'h0);
        read_byte(1'b0, rb);
        check("R1 mode cleared", {31'h0, rb[7]}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule